// File: doc/BRIEF.md
# Physical Register Ready Tracker

This block keeps one ready bit per physical register for an out-of-order core, with a separate table for the integer class and one for the floating-point class. Rename allocation marks a freshly assigned destination busy, a result writeback marks the produced register ready, and a replay re-marks a register busy so that consumers wait for the re-executed producer. Dispatch reads the ready bits of its source operands through combinational lookup ports, one result per read port and per class.

A single flush input, raised by the surrounding control when a valid redirect is an exception or a pipeline flush, returns both tables to the all-ready state. Within one cycle, writeback sets are applied first and busy marks from allocation and replay after them, while a flush overrides every other update. Lookups show the table as it stood at the start of the cycle; nothing written in the same cycle is forwarded to them.

Top module: `pregReadyTables`

## Requirements
- R1: After reset every bit of both tables is 1 (ready), and every lookup reports ready.
- R2: An allocation port with allocIsInt=1 marks its register busy (0) in the integer table only; with allocIsFp=1 it marks it busy in the floating-point table only.
- R3: An integer writeback marks its pdest ready only when intWbValid, intWbRfWen are both 1 and its intWbLdest is nonzero; otherwise the register stays busy.
- R4: A floating-point writeback marks its pdest ready when fpWbValid and fpWbFpWen are both 1; without fpWbFpWen the register stays busy.
- R5: Each lookup port returns, in the same cycle, the stored ready bit of the register at its address; a writeback in that cycle is not visible on the lookup until the next cycle.
- R6: A replay port marks its register busy in the table of the class selected by replayIsInt or replayIsFp, leaving the other table unchanged.
- R7: A flush makes every register of both tables ready at the next clock edge, overriding allocation, writeback and replay in the same cycle.
- R8: When a writeback and an allocation or replay name the same register in the same cycle, that register ends busy.
- R9: Registers named by no update keep their value.
- R10: intReadyState and fpReadyState expose the stored tables, bit i being the ready bit of register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Exception or pipeline-flush wipe of both tables |
| allocPreg | input | ALLOC_PORTS*IDX_W | Allocated register index per port |
| allocIsInt | input | ALLOC_PORTS | Allocation targets the integer table |
| allocIsFp | input | ALLOC_PORTS | Allocation targets the floating-point table |
| replayPreg | input | REPLAY_PORTS*IDX_W | Replayed register index per port |
| replayIsInt | input | REPLAY_PORTS | Replay targets the integer table |
| replayIsFp | input | REPLAY_PORTS | Replay targets the floating-point table |
| intWbValid | input | INT_WB_PORTS | Integer writeback valid |
| intWbRfWen | input | INT_WB_PORTS | Integer micro-op writes the register file |
| intWbLdest | input | INT_WB_PORTS*LDEST_W | Logical destination of the integer writeback |
| intWbPdest | input | INT_WB_PORTS*IDX_W | Physical destination of the integer writeback |
| fpWbValid | input | FP_WB_PORTS | Floating-point writeback valid |
| fpWbFpWen | input | FP_WB_PORTS | Floating-point write enable |
| fpWbPdest | input | FP_WB_PORTS*IDX_W | Physical destination of the floating-point writeback |
| intRdAddr | input | INT_RD_PORTS*IDX_W | Integer lookup addresses |
| intRdReady | output | INT_RD_PORTS | Integer lookup results |
| fpRdAddr | input | FP_RD_PORTS*IDX_W | Floating-point lookup addresses |
| fpRdReady | output | FP_RD_PORTS | Floating-point lookup results |
| intReadyState | output | NUM_PREGS | Stored integer table |
| fpReadyState | output | NUM_PREGS | Stored floating-point table |

## Verification
Lookup results are combinational, so the bench sets addresses on a falling edge and reads the ready outputs a moment later in the same cycle, before any clock edge. Table updates pass through one register: inputs driven on a falling edge are sampled at the next rising edge and the stored state is read at the falling edge after it, when the inputs are also cleared. The no-bypass case is checked by reading a lookup while a qualifying writeback is held, then again one cycle later.

// File: rtl/prtPkg.sv
package prtPkg;
  typedef enum logic {CLS_INT = 1'b0, CLS_FP = 1'b1} regClass_e;
endpackage

// File: rtl/prtUpdateCtrl.sv
module prtUpdateCtrl
  import prtPkg::*;
#(
  parameter regClass_e CLS = CLS_INT,
  parameter int NUM_PREGS = 64,
  parameter int ALLOC_PORTS = 4,
  parameter int WB_PORTS = 4,
  parameter int REPLAY_PORTS = 2,
  parameter int LDEST_W = 5,
  localparam int IDX_W = $clog2(NUM_PREGS)
) (
  input  logic                          flush,
  input  logic [ALLOC_PORTS*IDX_W-1:0]  allocPreg,
  input  logic [ALLOC_PORTS-1:0]        allocVld,
  input  logic [REPLAY_PORTS*IDX_W-1:0] replayPreg,
  input  logic [REPLAY_PORTS-1:0]       replayVld,
  input  logic [WB_PORTS-1:0]           wbValid,
  input  logic [WB_PORTS-1:0]           wbWen,
  input  logic [WB_PORTS*LDEST_W-1:0]   wbLdest,
  input  logic [WB_PORTS*IDX_W-1:0]     wbPdest,
  output logic                          wipe,
  output logic [NUM_PREGS-1:0]          setRdy,
  output logic [NUM_PREGS-1:0]          setBusy
);
  // Integer class excludes logical register zero; floating point does not.
  logic [WB_PORTS-1:0] wbQual;
  for (genvar w = 0; w < WB_PORTS; w++) begin : g_wbq
    assign wbQual[w] = wbValid[w] & wbWen[w] &
                       ((CLS == CLS_FP) || (wbLdest[w*LDEST_W +: LDEST_W] != '0));
  end

  always_comb begin
    setRdy  = '0;
    setBusy = '0;
    for (int r = 0; r < NUM_PREGS; r++) begin
      for (int w = 0; w < WB_PORTS; w++)
        if (wbQual[w] && (wbPdest[w*IDX_W +: IDX_W] == IDX_W'(r))) setRdy[r] = 1'b1;
      for (int a = 0; a < ALLOC_PORTS; a++)
        if (allocVld[a] && (allocPreg[a*IDX_W +: IDX_W] == IDX_W'(r))) setBusy[r] = 1'b1;
      for (int p = 0; p < REPLAY_PORTS; p++)
        if (replayVld[p] && (replayPreg[p*IDX_W +: IDX_W] == IDX_W'(r))) setBusy[r] = 1'b1;
    end
  end

  assign wipe = flush;
endmodule

// File: rtl/prtStore.sv
module prtStore #(
  parameter int NUM_PREGS = 64,
  parameter int RD_PORTS = 8,
  localparam int IDX_W = $clog2(NUM_PREGS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wipe,
  input  logic [NUM_PREGS-1:0]      setRdy,
  input  logic [NUM_PREGS-1:0]      setBusy,
  input  logic [RD_PORTS*IDX_W-1:0] rdAddr,
  output logic [RD_PORTS-1:0]       rdReady,
  output logic [NUM_PREGS-1:0]      readyQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     readyQ <= '1;
    else if (wipe) readyQ <= '1;
    else           readyQ <= (readyQ | setRdy) & ~setBusy;
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rdReady[p] = readyQ[rdAddr[p*IDX_W +: IDX_W]];
  end

  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  p_flush_all_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
    (armed && wipe) |=> (readyQ == '1));
  p_busy_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !wipe) |=> ((readyQ & $past(setBusy)) == '0));
  p_wb_sets_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !wipe) |=> ((readyQ & $past(setRdy & ~setBusy)) == $past(setRdy & ~setBusy)));
  p_untouched_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !wipe) |=> (((readyQ ^ $past(readyQ)) & ~$past(setRdy | setBusy)) == '0));
endmodule

// File: rtl/pregReadyTables.sv
module pregReadyTables
  import prtPkg::*;
#(
  parameter int NUM_PREGS = 64,
  parameter int ALLOC_PORTS = 4,
  parameter int REPLAY_PORTS = 2,
  parameter int INT_WB_PORTS = 4,
  parameter int FP_WB_PORTS = 4,
  parameter int INT_RD_PORTS = 8,
  parameter int FP_RD_PORTS = 8,
  parameter int LDEST_W = 5,
  localparam int IDX_W = $clog2(NUM_PREGS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          flush,
  input  logic [ALLOC_PORTS*IDX_W-1:0]  allocPreg,
  input  logic [ALLOC_PORTS-1:0]        allocIsInt,
  input  logic [ALLOC_PORTS-1:0]        allocIsFp,
  input  logic [REPLAY_PORTS*IDX_W-1:0] replayPreg,
  input  logic [REPLAY_PORTS-1:0]       replayIsInt,
  input  logic [REPLAY_PORTS-1:0]       replayIsFp,
  input  logic [INT_WB_PORTS-1:0]       intWbValid,
  input  logic [INT_WB_PORTS-1:0]       intWbRfWen,
  input  logic [INT_WB_PORTS*LDEST_W-1:0] intWbLdest,
  input  logic [INT_WB_PORTS*IDX_W-1:0] intWbPdest,
  input  logic [FP_WB_PORTS-1:0]        fpWbValid,
  input  logic [FP_WB_PORTS-1:0]        fpWbFpWen,
  input  logic [FP_WB_PORTS*IDX_W-1:0]  fpWbPdest,
  input  logic [INT_RD_PORTS*IDX_W-1:0] intRdAddr,
  output logic [INT_RD_PORTS-1:0]       intRdReady,
  input  logic [FP_RD_PORTS*IDX_W-1:0]  fpRdAddr,
  output logic [FP_RD_PORTS-1:0]        fpRdReady,
  output logic [NUM_PREGS-1:0]          intReadyState,
  output logic [NUM_PREGS-1:0]          fpReadyState
);
  logic                 intWipe, fpWipe;
  logic [NUM_PREGS-1:0] intSetRdy, intSetBusy, fpSetRdy, fpSetBusy;

  prtUpdateCtrl #(.CLS(CLS_INT), .NUM_PREGS(NUM_PREGS), .ALLOC_PORTS(ALLOC_PORTS),
    .WB_PORTS(INT_WB_PORTS), .REPLAY_PORTS(REPLAY_PORTS), .LDEST_W(LDEST_W)) u_intCtrl (
    .flush(flush), .allocPreg(allocPreg), .allocVld(allocIsInt),
    .replayPreg(replayPreg), .replayVld(replayIsInt),
    .wbValid(intWbValid), .wbWen(intWbRfWen), .wbLdest(intWbLdest), .wbPdest(intWbPdest),
    .wipe(intWipe), .setRdy(intSetRdy), .setBusy(intSetBusy));

  prtUpdateCtrl #(.CLS(CLS_FP), .NUM_PREGS(NUM_PREGS), .ALLOC_PORTS(ALLOC_PORTS),
    .WB_PORTS(FP_WB_PORTS), .REPLAY_PORTS(REPLAY_PORTS), .LDEST_W(1)) u_fpCtrl (
    .flush(flush), .allocPreg(allocPreg), .allocVld(allocIsFp),
    .replayPreg(replayPreg), .replayVld(replayIsFp),
    .wbValid(fpWbValid), .wbWen(fpWbFpWen), .wbLdest({FP_WB_PORTS{1'b1}}), .wbPdest(fpWbPdest),
    .wipe(fpWipe), .setRdy(fpSetRdy), .setBusy(fpSetBusy));

  prtStore #(.NUM_PREGS(NUM_PREGS), .RD_PORTS(INT_RD_PORTS)) u_intStore (
    .clk(clk), .rstN(rstN), .wipe(intWipe), .setRdy(intSetRdy), .setBusy(intSetBusy),
    .rdAddr(intRdAddr), .rdReady(intRdReady), .readyQ(intReadyState));

  prtStore #(.NUM_PREGS(NUM_PREGS), .RD_PORTS(FP_RD_PORTS)) u_fpStore (
    .clk(clk), .rstN(rstN), .wipe(fpWipe), .setRdy(fpSetRdy), .setBusy(fpSetBusy),
    .rdAddr(fpRdAddr), .rdReady(fpRdReady), .readyQ(fpReadyState));
endmodule

// File: tb/pregReadyTables_bench.sv
module pregReadyTables_bench;
  localparam int N = 64, IW = 6, AP = 4, RP = 2, WB = 4, RD = 8, LW = 5;

  logic clk = 1'b0, rstN = 1'b0, flush;
  logic [AP*IW-1:0] allocPreg;  logic [AP-1:0] allocIsInt, allocIsFp;
  logic [RP*IW-1:0] replayPreg; logic [RP-1:0] replayIsInt, replayIsFp;
  logic [WB-1:0] intWbValid, intWbRfWen; logic [WB*LW-1:0] intWbLdest; logic [WB*IW-1:0] intWbPdest;
  logic [WB-1:0] fpWbValid, fpWbFpWen; logic [WB*IW-1:0] fpWbPdest;
  logic [RD*IW-1:0] intRdAddr, fpRdAddr;
  logic [RD-1:0] intRdReady, fpRdReady;
  logic [N-1:0] intReadyState, fpReadyState;

  int checks = 0, failures = 0;
  logic [N-1:0] expInt, expFp;

  always #5 clk = ~clk;

  pregReadyTables u_pregReadyTables (.*);

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    flush = 0; allocPreg = '0; allocIsInt = '0; allocIsFp = '0;
    replayPreg = '0; replayIsInt = '0; replayIsFp = '0;
    intWbValid = '0; intWbRfWen = '0; intWbLdest = '0; intWbPdest = '0;
    fpWbValid = '0; fpWbFpWen = '0; fpWbPdest = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic checkTables(input string req);
    chk({req, " int"}, intReadyState, expInt);
    chk({req, " fp"}, fpReadyState, expFp);
  endtask

  task automatic t_reset();
    chk("R1 int", intReadyState, '1);
    chk("R1 fp", fpReadyState, '1);
    intRdAddr[0 +: IW] = 6'd17; fpRdAddr[3*IW +: IW] = 6'd63; #1;
    chk("R1 lookup", {62'd0, intRdReady[0], fpRdReady[3]}, 64'd3);
  endtask

  task automatic t_alloc();
    allocPreg[0 +: IW] = 6'd5; allocIsInt[0] = 1;
    allocPreg[IW +: IW] = 6'd9; allocIsFp[1] = 1;
    tick();
    expInt[5] = 0; expFp[9] = 0;
    checkTables("R2 R9 R10");
    intRdAddr[0 +: IW] = 6'd5; intRdAddr[7*IW +: IW] = 6'd9;
    fpRdAddr[0 +: IW] = 6'd9; fpRdAddr[1*IW +: IW] = 6'd5; #1;
    chk("R5 lookup", {60'd0, intRdReady[0], intRdReady[7], fpRdReady[0], fpRdReady[1]}, 64'b0101);
  endtask

  task automatic t_intWb();
    intWbValid[1] = 1; intWbRfWen[1] = 1; intWbLdest[LW +: LW] = 0; intWbPdest[IW +: IW] = 6'd5;
    tick(); checkTables("R3 ldest zero");
    intWbValid[2] = 1; intWbRfWen[2] = 0; intWbLdest[2*LW +: LW] = 3; intWbPdest[2*IW +: IW] = 6'd5;
    tick(); checkTables("R3 no rfwen");
    @(negedge clk);
    intWbValid[3] = 1; intWbRfWen[3] = 1; intWbLdest[3*LW +: LW] = 3; intWbPdest[3*IW +: IW] = 6'd5;
    intRdAddr[0 +: IW] = 6'd5; #1;
    chk("R5 no bypass", {63'd0, intRdReady[0]}, 64'd0);
    @(negedge clk); idle(); #1;
    expInt[5] = 1;
    checkTables("R3 qualified");
    chk("R5 next cycle", {63'd0, intRdReady[0]}, 64'd1);
  endtask

  task automatic t_fpWb();
    fpWbValid[0] = 1; fpWbFpWen[0] = 0; fpWbPdest[0 +: IW] = 6'd9;
    tick(); checkTables("R4 no fpwen");
    fpWbValid[2] = 1; fpWbFpWen[2] = 1; fpWbPdest[2*IW +: IW] = 6'd9;
    tick(); expFp[9] = 1; checkTables("R4 qualified");
  endtask

  task automatic t_replay();
    replayPreg[0 +: IW] = 6'd7; replayIsInt[0] = 1;
    replayPreg[IW +: IW] = 6'd40; replayIsFp[1] = 1;
    tick(); expInt[7] = 0; expFp[40] = 0; checkTables("R6");
  endtask

  task automatic t_collide();
    intWbValid[0] = 1; intWbRfWen[0] = 1; intWbLdest[0 +: LW] = 1; intWbPdest[0 +: IW] = 6'd10;
    allocPreg[2*IW +: IW] = 6'd10; allocIsInt[2] = 1;
    fpWbValid[1] = 1; fpWbFpWen[1] = 1; fpWbPdest[IW +: IW] = 6'd40;
    replayPreg[0 +: IW] = 6'd40; replayIsFp[0] = 1;
    intWbValid[3] = 1; intWbRfWen[3] = 1; intWbLdest[3*LW +: LW] = 2; intWbPdest[3*IW +: IW] = 6'd7;
    tick(); expInt[10] = 0; expInt[7] = 1; checkTables("R8");
  endtask

  task automatic t_flush();
    allocPreg[0 +: IW] = 6'd20; allocIsInt[0] = 1; allocIsFp[0] = 1;
    replayPreg[IW +: IW] = 6'd33; replayIsInt[1] = 1; replayIsFp[1] = 1;
    flush = 1;
    tick(); expInt = '1; expFp = '1; checkTables("R7");
  endtask

  initial begin
    idle(); intRdAddr = '0; fpRdAddr = '0;
    expInt = '1; expFp = '1;
    repeat (3) @(negedge clk);
    rstN = 1; #1;
    t_reset();
    t_alloc();
    t_intWb();
    t_fpWb();
    t_replay();
    t_collide();
    t_flush();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule